// File: doc/BRIEF.md
# Multichannel scaler bin accumulator

This block builds a time histogram of pulse arrivals by adding up many repeated sweeps. It counts rising edges on a single input. Time is cut into a run of bins of equal width, measured in clocks. When a bin closes, the block reads the matching word of a shared memory, adds the number of edges seen during that bin, and writes the sum back. After the last bin of a sweep it increments a sweep tally held in memory word 0. It then waits out a programmed dead time. After that it waits for the arm input before starting the next sweep. This repeats for a programmed number of sweeps.

Bin boundaries are placed by adding the bin width to the previous boundary target, never to the time at which the logic reacted, so slow memory traffic cannot make boundaries drift. The edge count of each bin is captured on the exact boundary clock, and the memory update runs behind it. A boundary that arrives while the previous update is still in progress raises a sticky overrun flag. A typical setting is a bin width of 120 clocks, 5 bins, 100000 sweeps and 160000 clocks of dead time.

The memory port is synchronous. Read data appears on `mem_rdata` one clock after the address is presented with `mem_we` low. A write takes effect at the clock edge where `mem_we` is high.

Top module: `mcs_accum`

## Requirements
- R1: After reset, `running`, `done`, `active`, `marker`, `overrun` and `mem_we` are all low.
- R2: A one-clock `start` pulse is accepted while the block is idle or done. It raises `running`, and it clears `done` and `overrun`.
- R3: A sweep begins only on a clock where `arm` is high. While `arm` stays low before a sweep, there is no marker, `active` stays low and no memory write occurs.
- R4: Bin k of a sweep starts exactly k times `cfg_bin_width` clocks after the clock on which the sweep was armed. `marker` is high for one clock at the start of every bin, so markers within a sweep are exactly `cfg_bin_width` clocks apart.
- R5: Memory word 1+i accumulates the rising edges seen during bin i (bins numbered from 0). Each update reads the word, then writes the read value plus the bin count to the same address on the next clock. Words above `cfg_num_bins` are never written.
- R6: Memory word 0 is incremented by exactly one for each completed sweep, after that sweep's last bin.
- R7: `active` is high from the arming clock until the last bin boundary of the sweep, and low during the dead time. Let L be the last bin boundary. When `arm` is already high, the next sweep's first marker comes exactly max(`cfg_dead_time`, 6) + 1 clocks after L.
- R8: When the dead time after the final sweep ends, `running` falls and `done` rises. `done` then stays high until the next accepted `start`.
- R9: With `cfg_bin_width` of 3 or more, `overrun` stays low. With a width of 2 or less, the first boundary that meets an unfinished update sets `overrun`, which holds until the next accepted `start`.
- R10: `edge_in` passes through a `SYNC_STAGES`-deep synchroniser. Each low-to-high transition counts exactly once, and a transition that completes at least `SYNC_STAGES`+1 clocks before a boundary counts in the bin that closes at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run of sweeps (one-clock pulse) |
| arm | input | 1 | Allows the next sweep to begin |
| edge_in | input | 1 | Pulse input whose rising edges are counted |
| cfg_bin_width | input | TIME_W | Bin width in clocks |
| cfg_num_bins | input | ADDR_W | Bins per sweep |
| cfg_num_sweeps | input | SWEEP_W | Sweeps per run |
| cfg_dead_time | input | TIME_W | Clocks from the last boundary to the earliest next sweep |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one clock after the address |
| marker | output | 1 | One-clock pulse at the start of each bin |
| active | output | 1 | High while bins are accumulating |
| running | output | 1 | High from start until all sweeps finish |
| done | output | 1 | High after the final sweep, until the next start |
| overrun | output | 1 | Sticky flag: a boundary met an unfinished memory update |

## Verification
A wrong boundary target shows within one bin, as marker spacing that differs from the programmed width. A wrong snapshot or adder shows only in the memory totals once the run ends. This is why the totals are compared word by word against sums of the known pulse patterns, over several sweeps. A stuck sequencer shows as a missing marker or a `done` that never rises. The gap between the last boundary and the next marker exposes errors in the dead-time accounting within a single sweep.

// File: rtl/mcs_accum_pkg.sv
package mcs_accum_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ARM, ST_BINS, ST_LAST, ST_DEAD, ST_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      RMW_IDLE, RMW_READ, RMW_WRITE
   } rmw_phase_t;
endpackage

// File: rtl/mcs_edge_counter.sv
module mcs_edge_counter #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_in,
   output logic [CNT_W-1:0] count
);
   logic sampled;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sampled = edge_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= (chain << 1) | SYNC_STAGES'(edge_in);
         end
         assign sampled = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         count  <= '0;
      end else begin
         prev_q <= sampled;
         if (sampled && !prev_q) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/mcs_bin_timer.sv
module mcs_bin_timer #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [TIME_W-1:0] amount,
   output logic              reached
);
   logic [TIME_W-1:0] now_q;
   logic [TIME_W-1:0] target_q;
   logic [TIME_W-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q    <= '0;
         target_q <= '0;
      end else begin
         now_q <= now_q + 1'b1;
         if (load)      target_q <= now_q + amount;
         else if (step) target_q <= target_q + amount;
      end
   end

   // Modular distance: the target counts as reached once now is at or past it.
   assign diff    = now_q - target_q;
   assign reached = ~diff[TIME_W-1];
endmodule

// File: rtl/mcs_rmw_port.sv
module mcs_rmw_port
   import mcs_accum_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_add,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   rmw_phase_t        phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] add_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= RMW_IDLE;
         addr_q  <= '0;
         add_q   <= '0;
      end else if (req) begin
         phase_q <= RMW_READ;
         addr_q  <= req_addr;
         add_q   <= req_add;
      end else begin
         case (phase_q)
            RMW_READ:  phase_q <= RMW_WRITE;
            RMW_WRITE: phase_q <= RMW_IDLE;
            default:   phase_q <= RMW_IDLE;
         endcase
      end
   end

   assign busy      = (phase_q != RMW_IDLE);
   assign mem_addr  = addr_q;
   assign mem_we    = (phase_q == RMW_WRITE);
   assign mem_wdata = mem_rdata + add_q;
endmodule

// File: rtl/mcs_accum.sv
module mcs_accum
   import mcs_accum_pkg::*;
#(
   parameter int TIME_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SWEEP_W     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               arm,
   input  logic               edge_in,
   input  logic [TIME_W-1:0]  cfg_bin_width,
   input  logic [ADDR_W-1:0]  cfg_num_bins,
   input  logic [SWEEP_W-1:0] cfg_num_sweeps,
   input  logic [TIME_W-1:0]  cfg_dead_time,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_we,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               marker,
   output logic               active,
   output logic               running,
   output logic               done,
   output logic               overrun
);
   localparam int MAX_BINS = (1 << ADDR_W) - 1;

   generate
      if (TIME_W < 4)       begin : g_bad_time  $error("TIME_W too small"); end
      if (ADDR_W < 1)       begin : g_bad_addr  $error("ADDR_W must be positive"); end
      if (DATA_W < 2)       begin : g_bad_data  $error("DATA_W too small"); end
      if (SWEEP_W < 1)      begin : g_bad_sweep $error("SWEEP_W must be positive"); end
      if (SYNC_STAGES < 0)  begin : g_bad_sync  $error("SYNC_STAGES negative"); end
      if (MAX_BINS < 1)     begin : g_bad_bins  $error("no room for bins"); end
   endgenerate

   seq_state_t         st_q;
   logic [ADDR_W-1:0]  bin_idx_q;
   logic [SWEEP_W-1:0] sweeps_left_q;
   logic [DATA_W-1:0]  snap_q;
   logic [DATA_W-1:0]  count;
   logic [DATA_W-1:0]  bin_delta;
   logic               reached;
   logic               rmw_busy;
   logic               last_bin;
   logic               boundary;
   logic               timer_load;
   logic               timer_step;
   logic [TIME_W-1:0]  timer_amount;
   logic               rmw_req;
   logic [ADDR_W-1:0]  rmw_addr;
   logic [DATA_W-1:0]  rmw_add;
   logic               accept_start;

   mcs_edge_counter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(DATA_W)) u_edges (
      .clk(clk), .rst_n(rst_n), .edge_in(edge_in), .count(count)
   );

   mcs_bin_timer #(.TIME_W(TIME_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(timer_load), .step(timer_step),
      .amount(timer_amount), .reached(reached)
   );

   mcs_rmw_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmw (
      .clk(clk), .rst_n(rst_n), .req(rmw_req), .req_addr(rmw_addr),
      .req_add(rmw_add), .busy(rmw_busy), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // A bin count of zero configured bins behaves as one bin.
   assign last_bin     = ({1'b0, bin_idx_q} + 1'b1) >= {1'b0, cfg_num_bins};
   assign boundary     = (st_q == ST_BINS) && reached;
   assign bin_delta    = count - snap_q;
   assign accept_start = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));

   assign timer_load   = (st_q == ST_ARM) && arm;
   assign timer_step   = boundary;
   assign timer_amount = (boundary && last_bin) ? cfg_dead_time : cfg_bin_width;

   always_comb begin
      rmw_req  = 1'b0;
      rmw_addr = bin_idx_q + 1'b1;
      rmw_add  = bin_delta;
      if (boundary) begin
         rmw_req = 1'b1;
      end else if ((st_q == ST_LAST) && !rmw_busy) begin
         rmw_req  = 1'b1;
         rmw_addr = '0;
         rmw_add  = DATA_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         bin_idx_q     <= '0;
         sweeps_left_q <= '0;
         snap_q        <= '0;
         marker        <= 1'b0;
         active        <= 1'b0;
         running       <= 1'b0;
         done          <= 1'b0;
         overrun       <= 1'b0;
      end else begin
         marker <= 1'b0;
         if (boundary && rmw_busy) overrun <= 1'b1;
         case (st_q)
            ST_IDLE, ST_DONE: begin
               if (accept_start) begin
                  sweeps_left_q <= cfg_num_sweeps;
                  running       <= 1'b1;
                  done          <= 1'b0;
                  overrun       <= 1'b0;
                  st_q          <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (arm) begin
                  snap_q    <= count;
                  bin_idx_q <= '0;
                  marker    <= 1'b1;
                  active    <= 1'b1;
                  st_q      <= ST_BINS;
               end
            end
            ST_BINS: begin
               if (reached) begin
                  snap_q <= count;
                  if (last_bin) begin
                     active <= 1'b0;
                     st_q   <= ST_LAST;
                  end else begin
                     bin_idx_q <= bin_idx_q + 1'b1;
                     marker    <= 1'b1;
                  end
               end
            end
            ST_LAST: begin
               if (!rmw_busy) st_q <= ST_DEAD;
            end
            ST_DEAD: begin
               if (reached && !rmw_busy) begin
                  if (sweeps_left_q <= SWEEP_W'(1)) begin
                     running <= 1'b0;
                     done    <= 1'b1;
                     st_q    <= ST_DONE;
                  end else begin
                     sweeps_left_q <= sweeps_left_q - 1'b1;
                     st_q          <= ST_ARM;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mcs_accum_chk.sv
module mcs_accum_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              arm,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              marker,
   input logic              active,
   input logic              running,
   input logic              done,
   input logic              overrun
);
   p_marker_in_bins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      marker |-> active);

   p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (!$past(mem_we) && mem_addr == $past(mem_addr)));

   p_sweep_tally_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == '0) |-> mem_wdata == mem_rdata + 1'b1);

   p_arm_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(arm));

   p_active_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> running);

   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!running && !active));

   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !start) |=> overrun);
endmodule

bind mcs_accum mcs_accum_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mcs_accum_test.sv
`timescale 1ns/1ps
module mcs_accum_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        arm = 1'b0;
   logic        edge_in = 1'b0;
   logic [31:0] cfg_bin_width = 32'd16;
   logic [7:0]  cfg_num_bins = 8'd4;
   logic [31:0] cfg_num_sweeps = 32'd3;
   logic [31:0] cfg_dead_time = 32'd20;
   logic [7:0]  mem_addr;
   logic        mem_we;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        marker, active, running, done, overrun;

   mcs_accum uut (
      .clk(clk), .rst_n(rst_n), .start(start), .arm(arm), .edge_in(edge_in),
      .cfg_bin_width(cfg_bin_width), .cfg_num_bins(cfg_num_bins),
      .cfg_num_sweeps(cfg_num_sweeps), .cfg_dead_time(cfg_dead_time),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .marker(marker), .active(active),
      .running(running), .done(done), .overrun(overrun)
   );

   always #5 clk = ~clk;

   logic [31:0] mem [0:255];
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Stimulus generator and marker timing monitor
   int mk_count = 0;
   int last_mk = 0;
   int pend = 0;
   int maxk = 5;
   int exp_mem [0:255];
   int active_chk_at = -1;

   function automatic int pulses_for(input int b, input int s, input int mk);
      if (mk == 0) return 0;
      return (3 * b + 2 * s + 1) % (mk + 1);
   endfunction

   always @(negedge clk) begin
      int nb, b, s, gap;
      nb = (cfg_num_bins == 0) ? 1 : int'(cfg_num_bins);
      if (active_chk_at == cyc) begin
         chk(active == 1'b0, "R7 active low in dead time", active, 0);
         active_chk_at = -1;
      end
      if (marker) begin
         b = mk_count % nb;
         s = mk_count / nb;
         chk(active == 1'b1, "R7 active with marker", active, 1);
         if (b != 0) begin
            chk(cyc - last_mk == int'(cfg_bin_width), "R4 marker spacing",
                cyc - last_mk, cfg_bin_width);
         end else if (s > 0) begin
            gap = (int'(cfg_dead_time) >= 6 ? int'(cfg_dead_time) : 6) + 1;
            chk(cyc - (last_mk + int'(cfg_bin_width)) == gap, "R7 dead gap",
                cyc - (last_mk + int'(cfg_bin_width)), gap);
         end
         if (b == nb - 1) active_chk_at = cyc + int'(cfg_bin_width) + 1;
         last_mk = cyc;
         pend = pulses_for(b, s, maxk);
         exp_mem[1 + b] += pend;
         mk_count++;
      end
      if (pend > 0) begin
         if (!edge_in) edge_in = 1'b1;
         else begin
            edge_in = 1'b0;
            pend--;
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (!finished && cyc > 60000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic clear_model();
      for (int i = 0; i < 256; i++) begin
         mem[i] = '0;
         exp_mem[i] = 0;
      end
      mk_count = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, tag, done, 1);
   endtask

   task automatic check_totals(input int nb, input int sweeps, input string tag);
      chk(mem[0] == 32'(sweeps), "R6 sweep tally", mem[0], sweeps);
      for (int i = 1; i <= nb; i++)
         chk(mem[i] == 32'(exp_mem[i]), tag, mem[i], exp_mem[i]);
      chk(mem[nb + 1] == 32'd0, "R5 word past last bin untouched", mem[nb + 1], 0);
   endtask

   initial begin
      clear_model();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({running, done, active, marker, overrun, mem_we} == 6'b0, "R1 reset outputs",
          {running, done, active, marker, overrun, mem_we}, 0);

      // Run A: several bins and sweeps with varied pulse patterns
      cfg_bin_width = 16; cfg_num_bins = 4; cfg_num_sweeps = 3; cfg_dead_time = 20; maxk = 5;
      arm = 1'b0;
      pulse_start();
      chk(running == 1'b1, "R2 running after start", running, 1);
      begin
         int viol = 0;
         repeat (40) begin
            @(negedge clk);
            if (marker || active || mem_we) viol++;
         end
         chk(viol == 0, "R3 idle while disarmed", viol, 0);
      end
      arm = 1'b1;
      wait_done("R8 done after run A");
      chk(running == 1'b0, "R8 running low at end", running, 0);
      chk(overrun == 1'b0, "R9 no overrun at width 16", overrun, 0);
      check_totals(4, 3, "R5 R10 bin totals run A");
      repeat (10) @(negedge clk);
      chk(done == 1'b1 && running == 1'b0, "R8 done held", done, 1);

      // Run B: minimum safe width, no pulses, short dead time
      clear_model();
      cfg_bin_width = 3; cfg_num_bins = 2; cfg_num_sweeps = 2; cfg_dead_time = 0; maxk = 0;
      pulse_start();
      chk(done == 1'b0, "R2 done cleared by start", done, 0);
      wait_done("R8 done after run B");
      chk(overrun == 1'b0, "R9 no overrun at width 3", overrun, 0);
      check_totals(2, 2, "R5 zero totals run B");

      // Run C: one bin per sweep with pulses
      clear_model();
      cfg_bin_width = 20; cfg_num_bins = 1; cfg_num_sweeps = 4; cfg_dead_time = 9; maxk = 5;
      pulse_start();
      wait_done("R8 done after run C");
      check_totals(1, 4, "R5 R10 single bin totals run C");

      // Run D: width too short, overrun expected
      clear_model();
      cfg_bin_width = 2; cfg_num_bins = 3; cfg_num_sweeps = 1; cfg_dead_time = 8; maxk = 0;
      pulse_start();
      wait_done("R8 done after run D");
      chk(overrun == 1'b1, "R9 overrun at width 2", overrun, 1);
      repeat (5) @(negedge clk);
      chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

      arm = 1'b0;
      pulse_start();
      chk(overrun == 1'b0 && done == 1'b0 && running == 1'b1, "R2 start clears flags",
          {overrun, done, running}, 1);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule